// File: doc/BRIEF.md
# Frame Buffer Pixel Formatter

The formatter sits between the frame-buffer read FIFO and the panel timing logic of a TFT display pipeline. It accepts 32-bit memory words over a valid/ready stream and, on every cycle the timing logic raises the active-pixel strobe, presents one 24-bit RGB pixel on a registered output bus. Each 32-bit word carries either two 16-bit pixels or one 24-bit pixel. Mode inputs choose the pixel depth, the 16-bit colour layout, and two independent swaps that reorder bytes inside the word. A second input picks where the 24-bit pixel sits in the word.

A solid-colour override replaces memory data with one 24-bit colour. Its enable and colour are sampled only on a frame-start pulse, so a change takes effect from the next frame. An inversion input flips every bit of a produced pixel. If the strobe arrives and no word is held, the pixel is black and a sticky underrun flag is set.

On the input stream, a word is taken on any cycle where `wr_valid` and `wr_ready` are both high. The block stalls the stream by holding `wr_ready` low while a held word still has pixels left to emit. `wr_ready` goes high in the same cycle that the last pixel of the held word is consumed, so a continuously valid source never causes a bubble. The source must hold `wr_data` steady while `wr_valid` is high and `wr_ready` is low.

Top module: `fb_pixel_formatter`

## Requirements
- R1: `wr_ready` is high when no word is held, or when the held word's last pixel is consumed in that cycle. Otherwise it is low. A word is accepted when `wr_valid` and `wr_ready` are both high.
- R2: With `depth_sel` = 4'b1101 (24 bpp), each word yields one pixel. With 4'b1100 (16 bpp), or any other code, each word yields two pixels on two active cycles, which need not be adjacent.
- R3: Byte swap exchanges the two bytes inside each 16-bit half. Half swap then exchanges bits 31:16 with 15:0. In 16 bpp, the first pixel is bits 31:16 of the reordered word and the second is bits 15:0. With only half swap on, the lower-address half is therefore shown first.
- R4: With `fmt_565` = 1, a 16-bit pixel p is unpacked as R = p[15:11], G = p[10:5], B = p[4:0]. Each channel is widened to 8 bits by appending its own top bits.
- R5: With `fmt_565` = 0, p is unpacked as R = p[15:11], G = p[10:6], B = p[5:1], with intensity bit p[0]. Each 5-bit channel becomes {c, c[4:3], p[0]}.
- R6: In 24 bpp, `hi_align` = 0 takes the pixel from bits 23:0 of the reordered word and `hi_align` = 1 takes it from bits 31:8. Within the 24 bits, red is 23:16, green 15:8 and blue 7:0.
- R7: `ovr_en` and `ovr_color` (red 23:16, green 15:8, blue 7:0) are sampled only on a `frame_start` cycle. While the sampled enable is set, every active pixel with a held word shows the sampled colour, and words are still consumed as in R2.
- R8: `invert` = 1 flips all 24 bits of each pixel taken from memory or from the override colour.
- R9: A cycle with `pix_active` low makes `rgb_out` zero on the next cycle.
- R10: An active cycle with no word held makes `rgb_out` zero on the next cycle and sets `underrun`. `underrun` stays set until reset.
- R11: After reset, `rgb_out` is zero, `underrun` is low, `wr_ready` is high and the override is off.
- R12: `rgb_out` changes only on the clock edge that ends the active cycle it belongs to, so each pixel has one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Memory word valid |
| wr_data | input | 32 | Memory word |
| wr_ready | output | 1 | Block can take a word |
| pix_active | input | 1 | Active-pixel strobe from timing logic |
| frame_start | input | 1 | One-cycle pulse at frame boundary |
| depth_sel | input | 4 | Pixel depth code (1100 = 16 bpp, 1101 = 24 bpp) |
| fmt_565 | input | 1 | 16-bit layout: 1 = 5:6:5, 0 = 5:5:5 + intensity |
| swap_bytes | input | 1 | Byte swap inside each half |
| swap_halves | input | 1 | Exchange the two 16-bit halves |
| hi_align | input | 1 | 24 bpp pixel in upper 24 bits |
| invert | input | 1 | Invert all output data bits |
| ovr_en | input | 1 | Solid-colour override enable (frame-sampled) |
| ovr_color | input | 24 | Override colour |
| rgb_out | output | 24 | Registered RGB pixel |
| underrun | output | 1 | Sticky missing-data flag |

## Verification
The reference model is driven with continuously valid words in 16 bpp under all four swap settings. These runs distinguish the first-pixel half from the second and show whether the byte and half reorderings are applied independently. Words with extreme and random channel values are checked in both 16-bit layouts, which exposes the widening and the placement of the intensity bit. The 24 bpp runs in both alignments confirm one word per pixel and the alignment choice.

A random mix of valid gaps and strobe gaps covers words split across non-adjacent active cycles and forces underruns, which test the black output and the sticky flag. Override runs change the enable and colour mid-frame without a frame-start pulse, then with one. This separates a correct frame-sampled latch from a colour that is applied at once.

// File: rtl/fbpf_pkg.sv
package fbpf_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int CH_W   = 8;
  localparam int RGB_W  = 3 * CH_W;
  localparam int DEPTH_W = 4;
  localparam logic [DEPTH_W-1:0] DEPTH_16 = 4'b1100;
  localparam logic [DEPTH_W-1:0] DEPTH_24 = 4'b1101;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/fbpf_swap.sv
module fbpf_swap #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              bytes_i,
  input  logic              halves_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_W = HALF_W / 2;

  logic [WORD_W-1:0] byte_stage;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign byte_stage[h*HALF_W +: HALF_W] = bytes_i
      ? {word_i[h*HALF_W +: BYTE_W], word_i[h*HALF_W+BYTE_W +: BYTE_W]}
      : word_i[h*HALF_W +: HALF_W];
  end

  assign word_o = halves_i ? {byte_stage[HALF_W-1:0], byte_stage[WORD_W-1:HALF_W]}
                           : byte_stage;
endmodule

// File: rtl/fbpf_expand16.sv
module fbpf_expand16
  import fbpf_pkg::*;
(
  input  logic [HALF_W-1:0] pix_i,
  input  logic              is565_i,
  output rgb_t              rgb_o
);
  always_comb begin
    if (is565_i) begin
      rgb_o.r = {pix_i[15:11], pix_i[15:13]};
      rgb_o.g = {pix_i[10:5],  pix_i[10:9]};
      rgb_o.b = {pix_i[4:0],   pix_i[4:2]};
    end else begin
      rgb_o.r = {pix_i[15:11], pix_i[15:14], pix_i[0]};
      rgb_o.g = {pix_i[10:6],  pix_i[10:9],  pix_i[0]};
      rgb_o.b = {pix_i[5:1],   pix_i[5:4],   pix_i[0]};
    end
  end
endmodule

// File: rtl/fbpf_hold.sv
module fbpf_hold #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [WORD_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic              take_i,
  input  logic              wide_i,
  output logic [WORD_W-1:0] word_o,
  output logic              have_o,
  output logic              second_o
);
  logic [WORD_W-1:0] word_q;
  logic              have_q;
  logic              second_q;
  logic              last_use;

  assign last_use   = take_i && have_q && (wide_i || second_q);
  assign in_ready_o = !have_q || last_use;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q   <= '0;
      have_q   <= 1'b0;
      second_q <= 1'b0;
    end else if (in_valid_i && in_ready_o) begin
      word_q   <= in_data_i;
      have_q   <= 1'b1;
      second_q <= 1'b0;
    end else if (last_use) begin
      have_q   <= 1'b0;
      second_q <= 1'b0;
    end else if (take_i && have_q) begin
      second_q <= 1'b1;
    end
  end

  assign word_o   = word_q;
  assign have_o   = have_q;
  assign second_o = second_q;

  // R1: an accepted word is held on the next cycle
  p_accept_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i && in_ready_o |=> have_q && word_q == $past(in_data_i));

  // R1: a held word with pixels left blocks the stream
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    have_q && !take_i |-> !in_ready_o);

  // R2: first pixel of a 16 bpp word keeps the word for a second pixel
  p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && have_q && !wide_i && !second_q |=> have_q && second_q);
endmodule

// File: rtl/fb_pixel_formatter.sv
module fb_pixel_formatter
  import fbpf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [WORD_W-1:0]  wr_data,
  output logic               wr_ready,
  input  logic               pix_active,
  input  logic               frame_start,
  input  logic [DEPTH_W-1:0] depth_sel,
  input  logic               fmt_565,
  input  logic               swap_bytes,
  input  logic               swap_halves,
  input  logic               hi_align,
  input  logic               invert,
  input  logic               ovr_en,
  input  logic [RGB_W-1:0]   ovr_color,
  output logic [RGB_W-1:0]   rgb_out,
  output logic               underrun
);
  logic              wide;
  logic [WORD_W-1:0] held_word;
  logic              have;
  logic              second;
  logic [WORD_W-1:0] ordered;
  logic [HALF_W-1:0] half_pix;
  rgb_t              rgb16;
  logic [RGB_W-1:0]  rgb24;
  logic [RGB_W-1:0]  mem_pix;
  logic [RGB_W-1:0]  src_pix;
  logic              ovr_live_q;
  logic [RGB_W-1:0]  ovr_val_q;

  assign wide = (depth_sel == DEPTH_24);

  fbpf_hold #(.WORD_W(WORD_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (wr_valid),
    .in_data_i  (wr_data),
    .in_ready_o (wr_ready),
    .take_i     (pix_active),
    .wide_i     (wide),
    .word_o     (held_word),
    .have_o     (have),
    .second_o   (second)
  );

  fbpf_swap #(.WORD_W(WORD_W)) u_swap (
    .word_i   (held_word),
    .bytes_i  (swap_bytes),
    .halves_i (swap_halves),
    .word_o   (ordered)
  );

  assign half_pix = second ? ordered[HALF_W-1:0] : ordered[WORD_W-1:HALF_W];

  fbpf_expand16 u_expand (
    .pix_i   (half_pix),
    .is565_i (fmt_565),
    .rgb_o   (rgb16)
  );

  assign rgb24   = hi_align ? ordered[WORD_W-1:WORD_W-RGB_W] : ordered[RGB_W-1:0];
  assign mem_pix = wide ? rgb24 : rgb16;
  assign src_pix = ovr_live_q ? ovr_val_q : mem_pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_live_q <= 1'b0;
      ovr_val_q  <= '0;
    end else if (frame_start) begin
      ovr_live_q <= ovr_en;
      ovr_val_q  <= ovr_color;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_out  <= '0;
      underrun <= 1'b0;
    end else if (pix_active && have) begin
      rgb_out <= src_pix ^ {RGB_W{invert}};
    end else begin
      rgb_out <= '0;
      if (pix_active) underrun <= 1'b1;
    end
  end

  // R9: blanking cycles give black
  p_blank_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_active |=> rgb_out == '0);

  // R10: missing data gives black and raises the flag
  p_underrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_active && !have |=> underrun && rgb_out == '0);

  // R10: flag is sticky
  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R7: override latch moves only on frame start
  p_ovr_frame_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(ovr_live_q) && $stable(ovr_val_q));

  // R7: live override wins over memory data
  p_ovr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_live_q && pix_active && have |=>
      rgb_out == ($past(ovr_val_q) ^ {RGB_W{$past(invert)}}));
endmodule

// File: tb/tb_fb_pixel_formatter.sv
`timescale 1ns/1ps
module tb_fb_pixel_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready;
  logic        pix_active = 1'b0;
  logic        frame_start = 1'b0;
  logic [3:0]  depth_sel = 4'b1100;
  logic        fmt_565 = 1'b1;
  logic        swap_bytes = 1'b0;
  logic        swap_halves = 1'b0;
  logic        hi_align = 1'b0;
  logic        invert = 1'b0;
  logic        ovr_en = 1'b0;
  logic [23:0] ovr_color = '0;
  logic [23:0] rgb_out;
  logic        underrun;

  fb_pixel_formatter dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .pix_active(pix_active), .frame_start(frame_start),
    .depth_sel(depth_sel), .fmt_565(fmt_565), .swap_bytes(swap_bytes),
    .swap_halves(swap_halves), .hi_align(hi_align), .invert(invert),
    .ovr_en(ovr_en), .ovr_color(ovr_color), .rgb_out(rgb_out),
    .underrun(underrun)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R11";

  logic [31:0] q[$];
  logic [31:0] m_word;
  bit          m_have, m_second, m_ur, m_live;
  logic [23:0] m_ovr;

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [23:0] ref_pixel(input logic [31:0] w, input bit second);
    logic [7:0]  b [4];
    logic [7:0]  t;
    logic [31:0] o;
    int p, r, g, bl, i;
    for (int k = 0; k < 4; k++) b[k] = w[8*k +: 8];
    if (swap_bytes) begin
      t = b[0]; b[0] = b[1]; b[1] = t;
      t = b[2]; b[2] = b[3]; b[3] = t;
    end
    if (swap_halves) begin
      t = b[0]; b[0] = b[2]; b[2] = t;
      t = b[1]; b[1] = b[3]; b[3] = t;
    end
    o = {b[3], b[2], b[1], b[0]};
    if (depth_sel == 4'b1101) return hi_align ? o[31:8] : o[23:0];
    p = second ? int'(o[15:0]) : int'(o[31:16]);
    if (fmt_565) begin
      r = (p >> 11) & 31; g = (p >> 5) & 63; bl = p & 31;
      r = (r << 3) | (r >> 2); g = (g << 2) | (g >> 4); bl = (bl << 3) | (bl >> 2);
    end else begin
      i = p & 1;
      r = (p >> 11) & 31; g = (p >> 6) & 31; bl = (p >> 1) & 31;
      r = (r << 3) | ((r >> 3) << 1) | i;
      g = (g << 3) | ((g >> 3) << 1) | i;
      bl = (bl << 3) | ((bl >> 3) << 1) | i;
    end
    return {r[7:0], g[7:0], bl[7:0]};
  endfunction

  task automatic step(input bit act, input bit gate, input bit fs);
    bit exp_ready, acc, last;
    logic [23:0] exp_pix;
    @(negedge clk);
    pix_active  = act;
    frame_start = fs;
    wr_valid    = gate && (q.size() > 0);
    wr_data     = wr_valid ? q[0] : 32'h0;
    #1;
    last      = act && m_have && ((depth_sel == 4'b1101) || m_second);
    exp_ready = !m_have || last;
    chk(wr_ready == exp_ready, "R1", {31'b0, wr_ready}, {31'b0, exp_ready});
    exp_pix = '0;
    if (act) begin
      if (m_have) begin
        exp_pix = m_live ? m_ovr : ref_pixel(m_word, m_second);
        if (invert) exp_pix = exp_pix ^ 24'hFFFFFF;
      end else m_ur = 1'b1;
    end
    acc = wr_valid && exp_ready;
    if (acc) begin
      m_word = wr_data; m_have = 1'b1; m_second = 1'b0;
      void'(q.pop_front());
    end else if (last) begin
      m_have = 1'b0; m_second = 1'b0;
    end else if (act && m_have) m_second = 1'b1;
    if (fs) begin m_live = ovr_en; m_ovr = ovr_color; end
    @(posedge clk); #1;
    chk(rgb_out == exp_pix, tag, {8'b0, rgb_out}, {8'b0, exp_pix});
    chk(underrun == m_ur, "R10", {31'b0, underrun}, {31'b0, m_ur});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; pix_active = 1'b0; frame_start = 1'b0;
    q.delete();
    repeat (2) @(negedge clk);
    m_have = 1'b0; m_second = 1'b0; m_ur = 1'b0; m_live = 1'b0; m_ovr = '0;
    rst_n = 1'b1;
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) q.push_back($urandom());
  endtask

  task automatic run_stream(input int n);
    step(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < n; k++) step(1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    do_reset();
    #1;
    // R11: reset state
    chk(rgb_out == 24'h0, "R11", {8'b0, rgb_out}, 32'h0);
    chk(underrun == 1'b0, "R11", {31'b0, underrun}, 32'h0);
    chk(wr_ready == 1'b1, "R11", {31'b0, wr_ready}, 32'h1);

    // R3 / R4: 16 bpp 5:6:5 under every swap setting
    for (int s = 0; s < 4; s++) begin
      do_reset();
      tag = "R3"; depth_sel = 4'b1100; fmt_565 = 1'b1;
      swap_bytes = s[0]; swap_halves = s[1];
      q.push_back(32'hFFFF_0000); q.push_back(32'h1234_ABCD); q.push_back(32'hF800_07E0);
      fill(20);
      run_stream(40);
    end

    // R4: extreme channel values, no swap
    do_reset();
    tag = "R4"; swap_bytes = 1'b0; swap_halves = 1'b0;
    q.push_back(32'h001F_F800); q.push_back(32'h07E0_8410);
    fill(10); run_stream(20);

    // R5: 5:5:5 plus intensity
    do_reset();
    tag = "R5"; fmt_565 = 1'b0;
    q.push_back(32'h0001_FFFE); q.push_back(32'h8421_7BDE);
    fill(20); run_stream(40);

    // R6: 24 bpp in both alignments, one word per pixel (R2)
    for (int a = 0; a < 2; a++) begin
      do_reset();
      tag = "R6"; depth_sel = 4'b1101; hi_align = a[0]; fmt_565 = 1'b1;
      q.push_back(32'hAABB_CCDD); fill(20); run_stream(20);
    end

    // R2: random valid and strobe gaps in both depths; underruns arise (R10)
    for (int d = 0; d < 2; d++) begin
      do_reset();
      tag = "R2"; depth_sel = d[0] ? 4'b1101 : 4'b1100; hi_align = 1'b0;
      swap_halves = 1'b1;
      fill(60);
      for (int k = 0; k < 120; k++) step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, 1'b0);
    end

    // R10: forced underrun, then flag holds while data flows again
    do_reset();
    tag = "R10"; depth_sel = 4'b1100; swap_halves = 1'b0;
    step(1'b1, 1'b0, 1'b0);
    fill(10);
    for (int k = 0; k < 12; k++) step(1'b1, 1'b1, 1'b0);

    // R8: inversion on memory data
    do_reset();
    tag = "R8"; invert = 1'b1;
    fill(10); run_stream(16);

    // R7: override enabled without frame start has no effect, then takes over
    do_reset();
    tag = "R7"; invert = 1'b0; ovr_en = 1'b1; ovr_color = 24'h12_34_56;
    fill(30);
    step(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0);
    ovr_color = 24'hFE_DC_BA; invert = 1'b1;
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 1'b0);
    ovr_en = 1'b0;
    step(1'b0, 1'b1, 1'b1);
    invert = 1'b0;
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0);

    // R9 / R12: blanking between pixels
    do_reset();
    tag = "R9"; fill(10);
    for (int k = 0; k < 20; k++) step(k[0], 1'b1, 1'b0);
    tag = "R12";
    for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule